// File: doc/BRIEF.md
# Output Bus Width and Endian Matcher

This block sits between the read side of a 36-bit FIFO and an output port whose width can be configured. The port can run as a full 36-bit long-word port, an 18-bit word port or a 9-bit byte port. In the narrow modes each stored entry is handed out as two or four smaller pieces, one on each accepted read strobe. The FIFO is popped only when the last piece of the entry is taken.

The FIFO is assumed to show its head entry on its read data while it is not empty. The matcher chooses one piece of that entry from an internal piece index and places it on the low bits of `out_data`. Piece order is set by an endian input: with most-significant-first the high half or high byte leads, and with least-significant-first the low half or low byte leads.

The endian, narrow-enable and size inputs are captured while the master reset is held low. After reset they are held in registers, so the output configuration stays fixed for the whole run even if the input pins change.

Top module: `bus_width_matcher`

## Requirements
- R1: With `bus_narrow` low at reset, `out_data` equals `fifo_rdata` in full, and every accepted read (`rd_en` high, `fifo_empty` low) asserts `fifo_pop` in the same cycle.
- R2: With `bus_narrow` high and `size_byte` low at reset, each entry is delivered as two 18-bit pieces on `out_data[17:0]`, with `out_data[35:18]` zero. The halves are bits 17:0 and 35:18.
- R3: With `bus_narrow` high and `size_byte` high at reset, each entry is delivered as four 9-bit pieces on `out_data[8:0]`, with `out_data[35:9]` zero. Byte n is bits 9n+8:9n.
- R4: `endian_sel` high during reset selects most-significant-first order: half 35:18 before 17:0, and byte 3 down to byte 0.
- R5: `endian_sel` low during reset selects least-significant-first order: half 17:0 first, and byte 0 up to byte 3.
- R6: `endian_sel`, `bus_narrow` and `size_byte` are sampled only on clock edges while `mrst_n` is low. Changing them after reset has no effect on `out_data`.
- R7: `fifo_pop` is high only in the cycle of an accepted read of the last piece of an entry. The next entry is then presented starting from its first piece.
- R8: A read strobe while `fifo_empty` is high does not advance the piece index and does not pop.
- R9: `out_empty` is high exactly when `fifo_empty` is high. No partial entry exists outside the FIFO, because the entry stays in the FIFO until its last piece is taken.
- R10: A master reset returns the piece index to the first piece, including in the middle of an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Synchronous master reset, active low; configuration is sampled while low |
| endian_sel | input | 1 | 1 = most significant piece first, 0 = least significant first |
| bus_narrow | input | 1 | 0 = 36-bit port, 1 = narrow port |
| size_byte | input | 1 | With narrow port: 1 = 9-bit pieces, 0 = 18-bit pieces |
| fifo_rdata | input | 36 | Head entry of the FIFO |
| fifo_empty | input | 1 | FIFO has no entry |
| rd_en | input | 1 | Read strobe from the output port |
| fifo_pop | output | 1 | Removes the head entry from the FIFO |
| out_data | output | 36 | Current piece, right-aligned and zero-extended |
| out_empty | output | 1 | No data available on the output port |

## Verification
A stuck or skipped piece index shows up on `out_data` at once. The wrong half or byte appears at the next sample after the faulty edge, and `fifo_pop` moves to the wrong read, so the following entry is lost or repeated. A configuration register that follows its pin after reset changes the piece width or order in the first cycle after the pin moves. An index that does not clear on reset or on pop leaves the first piece of an entry unseen on its first read.

// File: rtl/bm_pkg.sv
package bm_pkg;

   typedef enum logic [1:0] {
      WIDTH_LONG = 2'd0,
      WIDTH_WORD = 2'd1,
      WIDTH_BYTE = 2'd2
   } width_e;

   typedef struct packed {
      width_e width;
      logic   msb_first;
   } bm_cfg_t;

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
   import bm_pkg::*;
(
   input  logic    clk,
   input  logic    mrst_n,
   input  logic    endian_in,
   input  logic    narrow_in,
   input  logic    size_in,
   output bm_cfg_t cfg
);

   width_e width_d;

   always_comb begin
      if (!narrow_in)   width_d = WIDTH_LONG;
      else if (size_in) width_d = WIDTH_BYTE;
      else              width_d = WIDTH_WORD;
   end

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         cfg.width     <= width_d;
         cfg.msb_first <= endian_in;
      end
   end

endmodule

// File: rtl/bm_piece_ctr.sv
module bm_piece_ctr
   import bm_pkg::*;
#(
   parameter int LANES = 4,
   localparam int CNT_W = $clog2(LANES)
)(
   input  logic             clk,
   input  logic             mrst_n,
   input  bm_cfg_t          cfg,
   input  logic             advance,
   output logic [CNT_W-1:0] idx,
   output logic             last
);

   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] final_idx;

   always_comb begin
      case (cfg.width)
         WIDTH_WORD: final_idx = CNT_W'(1);
         WIDTH_BYTE: final_idx = CNT_W'(LANES - 1);
         default:    final_idx = '0;
      endcase
   end

   assign last = (idx_q == final_idx);
   assign idx  = idx_q;

   always_ff @(posedge clk) begin
      if (!mrst_n)      idx_q <= '0;
      else if (advance) idx_q <= last ? '0 : idx_q + 1'b1;
   end

endmodule

// File: rtl/bm_piece_mux.sv
module bm_piece_mux
   import bm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANE_W * LANES,
   localparam int HALF_W = DATA_W / 2,
   localparam int CNT_W  = $clog2(LANES)
)(
   input  bm_cfg_t           cfg,
   input  logic [DATA_W-1:0] word,
   input  logic [CNT_W-1:0]  idx,
   output logic [DATA_W-1:0] piece
);

   logic [LANE_W-1:0] lane [LANES];
   logic [HALF_W-1:0] half [2];
   logic [CNT_W-1:0]  lane_sel;
   logic              half_sel;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word[g*LANE_W +: LANE_W];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half[h] = word[h*HALF_W +: HALF_W];
   end

   assign lane_sel = cfg.msb_first ? (CNT_W'(LANES - 1) - idx) : idx;
   assign half_sel = cfg.msb_first ^ idx[0];

   always_comb begin
      case (cfg.width)
         WIDTH_WORD: piece = DATA_W'(half[half_sel]);
         WIDTH_BYTE: piece = DATA_W'(lane[lane_sel]);
         default:    piece = word;
      endcase
   end

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
   import bm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANE_W * LANES,
   localparam int CNT_W  = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              endian_sel,
   input  logic              bus_narrow,
   input  logic              size_byte,
   input  logic [DATA_W-1:0] fifo_rdata,
   input  logic              fifo_empty,
   input  logic              rd_en,
   output logic              fifo_pop,
   output logic [DATA_W-1:0] out_data,
   output logic              out_empty
);

   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two and at least 4");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be positive");
   end

   bm_cfg_t          cfg;
   logic [CNT_W-1:0] piece_idx;
   logic             piece_last;
   logic             accept;

   assign accept    = rd_en & ~fifo_empty;
   assign fifo_pop  = accept & piece_last;
   assign out_empty = fifo_empty;

   bm_cfg_latch u_cfg (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .endian_in (endian_sel),
      .narrow_in (bus_narrow),
      .size_in   (size_byte),
      .cfg       (cfg)
   );

   bm_piece_ctr #(.LANES(LANES)) u_ctr (
      .clk     (clk),
      .mrst_n  (mrst_n),
      .cfg     (cfg),
      .advance (accept),
      .idx     (piece_idx),
      .last    (piece_last)
   );

   bm_piece_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
      .cfg   (cfg),
      .word  (fifo_rdata),
      .idx   (piece_idx),
      .piece (out_data)
   );

endmodule

// File: rtl/bm_checker.sv
module bm_checker
   import bm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANE_W * LANES,
   localparam int CNT_W  = $clog2(LANES)
)(
   input logic              clk,
   input logic              mrst_n,
   input logic              rd_en,
   input logic              fifo_empty,
   input logic              fifo_pop,
   input logic              out_empty,
   input logic [DATA_W-1:0] out_data,
   input logic [CNT_W-1:0]  piece_idx,
   input bm_cfg_t           cfg
);

   assert_long_pop_R1: assert property (@(posedge clk) disable iff (!mrst_n)
      (cfg.width == WIDTH_LONG && rd_en && !fifo_empty) |-> fifo_pop);

   assert_word_upper_zero_R2: assert property (@(posedge clk) disable iff (!mrst_n)
      (cfg.width == WIDTH_WORD) |-> (out_data[DATA_W-1:DATA_W/2] == '0));

   assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!mrst_n)
      (cfg.width == WIDTH_BYTE) |-> (out_data[DATA_W-1:LANE_W] == '0));

   assert_pop_needs_read_R7: assert property (@(posedge clk) disable iff (!mrst_n)
      fifo_pop |-> (rd_en && !fifo_empty));

   assert_pop_restarts_R7: assert property (@(posedge clk) disable iff (!mrst_n)
      fifo_pop |=> (piece_idx == '0));

   assert_advance_R7: assert property (@(posedge clk) disable iff (!mrst_n)
      (rd_en && !fifo_empty && !fifo_pop) |=> (piece_idx == CNT_W'($past(piece_idx) + 1'b1)));

   assert_empty_read_hold_R8: assert property (@(posedge clk) disable iff (!mrst_n)
      (rd_en && fifo_empty) |=> $stable(piece_idx));

   assert_out_empty_R9: assert property (@(posedge clk) disable iff (!mrst_n)
      out_empty == fifo_empty);

   assert_reset_idx_R10: assert property (@(posedge clk)
      !mrst_n |=> (piece_idx == '0));

endmodule

bind bus_width_matcher bm_checker #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
   .clk        (clk),
   .mrst_n     (mrst_n),
   .rd_en      (rd_en),
   .fifo_empty (fifo_empty),
   .fifo_pop   (fifo_pop),
   .out_empty  (out_empty),
   .out_data   (out_data),
   .piece_idx  (piece_idx),
   .cfg        (cfg)
);

// File: tb/bus_width_matcher_tb_top.sv
module bus_width_matcher_tb_top;

   logic        clk = 1'b0;
   logic        mrst_n = 1'b0;
   logic        endian_sel = 1'b0;
   logic        bus_narrow = 1'b0;
   logic        size_byte = 1'b0;
   logic [35:0] fifo_rdata = '0;
   logic        fifo_empty = 1'b1;
   logic        rd_en = 1'b0;
   logic        fifo_pop;
   logic [35:0] out_data;
   logic        out_empty;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   bus_width_matcher dut_i (
      .clk(clk), .mrst_n(mrst_n), .endian_sel(endian_sel), .bus_narrow(bus_narrow),
      .size_byte(size_byte), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
      .rd_en(rd_en), .fifo_pop(fifo_pop), .out_data(out_data), .out_empty(out_empty)
   );

   // {endian, narrow, size, word, expected first piece}
   localparam logic [74:0] VEC [6] = '{
      {1'b0, 1'b0, 1'b0, 36'h123456789, 36'h123456789},
      {1'b1, 1'b0, 1'b0, 36'hFEDCBA987, 36'hFEDCBA987},
      {1'b0, 1'b1, 1'b0, 18'h1ABCD, 18'h0F00F, 36'h00000F00F},
      {1'b1, 1'b1, 1'b0, 18'h1ABCD, 18'h0F00F, 36'h00001ABCD},
      {1'b0, 1'b1, 1'b1, 9'h1A5, 9'h0C3, 9'h13C, 9'h07E, 36'h00000007E},
      {1'b1, 1'b1, 1'b1, 9'h1A5, 9'h0C3, 9'h13C, 9'h07E, 36'h0000001A5}
   };

   function automatic logic [35:0] exp_piece(logic e, logic n, logic s, logic [35:0] w, int k);
      int idx;
      if (!n) return w;
      if (!s) begin
         idx = e ? 1 - k : k;
         return {18'h0, w[idx*18 +: 18]};
      end
      idx = e ? 3 - k : k;
      return {27'h0, w[idx*9 +: 9]};
   endfunction

   function automatic int piece_count(logic n, logic s);
      return !n ? 1 : (s ? 4 : 2);
   endfunction

   task automatic check(string req, logic [35:0] act, logic [35:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(logic e, logic n, logic s);
      @(negedge clk);
      mrst_n = 1'b0; endian_sel = e; bus_narrow = n; size_byte = s; rd_en = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      mrst_n = 1'b1;
   endtask

   // Drain one entry piece by piece; checks data and pop before each edge.
   task automatic drain(string req, logic e, logic n, logic s, logic [35:0] w);
      int pcs;
      pcs = piece_count(n, s);
      for (int k = 0; k < pcs; k++) begin
         @(negedge clk);
         fifo_rdata = w; fifo_empty = 1'b0; rd_en = 1'b1;
         #1;
         check(req, out_data, exp_piece(e, n, s, w, k));
         check("R7", {35'h0, fifo_pop}, {35'h0, k == pcs - 1});
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state: first piece shown, out_empty follows fifo_empty (R9, R10)
      do_reset(1'b1, 1'b1, 1'b1);
      fifo_rdata = {9'h1A5, 9'h0C3, 9'h13C, 9'h07E};
      fifo_empty = 1'b1;
      #1;
      check("R9", {35'h0, out_empty}, 36'h1);
      check("R10", out_data, 36'h1A5);
      check("R8", {35'h0, fifo_pop}, 36'h0);

      // Vector table walk (R1..R5, R7)
      for (int v = 0; v < 6; v++) begin
         logic e, n, s;
         logic [35:0] w, first;
         {e, n, s, w, first} = VEC[v];
         do_reset(e, n, s);
         @(negedge clk);
         fifo_rdata = w; fifo_empty = 1'b0; rd_en = 1'b0;
         #1;
         check(e ? "R4" : "R5", out_data, first);
         check("R9", {35'h0, out_empty}, 36'h0);
         drain(!n ? "R1" : (s ? "R3" : "R2"), e, n, s, w);
         // second entry follows from its first piece
         drain("R7", e, n, s, ~w);
      end

      // R8: read strobe while empty does not advance or pop (byte, lsb first)
      do_reset(1'b0, 1'b1, 1'b1);
      @(negedge clk);
      fifo_rdata = {9'h111, 9'h022, 9'h033, 9'h044}; fifo_empty = 1'b0; rd_en = 1'b1;
      @(negedge clk);
      fifo_empty = 1'b1;
      #1;
      check("R8", {35'h0, fifo_pop}, 36'h0);
      check("R9", {35'h0, out_empty}, 36'h1);
      @(negedge clk);
      fifo_empty = 1'b0; rd_en = 1'b0;
      #1;
      check("R8", out_data, 36'h033);

      // R10: reset mid-entry returns to first piece
      do_reset(1'b0, 1'b1, 1'b1);
      @(negedge clk);
      rd_en = 1'b0;
      #1;
      check("R10", out_data, 36'h044);

      // R6: pin changes after reset are ignored (word mode, msb first)
      do_reset(1'b1, 1'b1, 1'b0);
      @(negedge clk);
      fifo_rdata = {18'h2C0DE, 18'h01234}; fifo_empty = 1'b0; rd_en = 1'b0;
      endian_sel = 1'b0; bus_narrow = 1'b0; size_byte = 1'b1;
      @(negedge clk);
      #1;
      check("R6", out_data, 36'h2C0DE);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
      check("R6", out_data, 36'h01234);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule